// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. An external integrator, a zero-crossing comparator and three analog switches do the analog work; the sequencer drives the switches, counts clock periods and reports the result. While idle it holds the integrator in auto-zero with its input grounded. A start command launches a conversion. First it integrates the unknown input for a fixed window of exactly 2^N clocks, timed by an N-bit counter that wraps to zero. It then switches the integrator to the opposite-polarity reference and counts clocks until the comparator reports that the integrator output has come back up to zero.

The final count is the conversion result, with Vin = Vref * count / 2^N. The comparator line is asynchronous to the clock, so it passes through a two-stage synchronizer before the sequencer acts on it. If the run-down never ends, the result saturates and an overrange flag is raised. The result and the end-of-conversion flag stay valid until software or a host controller issues the next start.

Top module: `dsadc_seq`

## Requirements
- R1: After reset and whenever no conversion is running, `az_sw_o`=1, `in_sel_o`=0 and `ref_sel_o`=0 (auto-zero closed, input on ground, reference off). After reset, `eoc_o`=0, `ovr_o`=0 and `result_o`=0.
- R2: A start sampled high while idle opens auto-zero and selects the analog input (`az_sw_o`=0, `in_sel_o`=1) from the next clock, with the counter restarted at zero.
- R3: The run-up phase (`in_sel_o`=1) lasts exactly 2^N clock cycles. It ends when the counter wraps from all ones to zero, and the next cycle has `ref_sel_o`=1.
- R4: During run-down, the counter advances only on cycles where the synchronized comparator reads 1 (integrator still negative). `cmp_neg_i` reaches the sequencer through two flops. If `cmp_neg_i` falls to 0 D cycles after the first run-down cycle, the result is D+2.
- R5: On the first synchronized sample showing 0, the count is stored in `result_o` and `eoc_o` rises. At that edge the sequencer returns to the idle switch settings. The run-down lasts D+3 cycles.
- R6: If the count reaches 2^N-1 while the synchronized comparator still reads 1, `result_o` is all ones, `ovr_o`=1 and `eoc_o`=1. The run-down then lasts exactly 2^N cycles.
- R7: `result_o`, `eoc_o` and `ovr_o` hold their values while idle, whatever the comparator does. `eoc_o` and `ovr_o` return to 0 one cycle after the next accepted start.
- R8: A start pulse during run-up or run-down is ignored: the phase lengths and the result are unchanged.
- R9: At most one of `az_sw_o`, `in_sel_o`, `ref_sel_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start command, sampled while idle |
| cmp_neg_i | input | 1 | Comparator: 1 while integrator output is negative, asynchronous |
| az_sw_o | output | 1 | Auto-zero switch closed |
| in_sel_o | output | 1 | Integrator fed from the analog input (0 means ground) |
| ref_sel_o | output | 1 | Integrator fed from the negative reference |
| result_o | output | N | Conversion count |
| eoc_o | output | 1 | End of conversion, held until the next start |
| ovr_o | output | 1 | Overrange, result saturated |

## Verification
The switch outputs are decoded from the state register, so each one changes in the cycle after the edge that moves the state. The checks read them at the falling edge that follows a start or a phase change. The end of run-down is due three edges after the comparator input falls: two edges cross the synchronizer and one registers the result. The bench therefore tallies the run-down cycles and compares them with D+3, or with 2^N on overrange, before it reads the result at the falling edge where `eoc_o` is first seen high. Held values are checked over several idle cycles in which the comparator toggles at random.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_ZERO = 2'd0,
    PH_UP   = 2'd1,
    PH_DOWN = 2'd2
  } phase_t;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= RST_VAL;
        end else if (g == 0) begin
          chain_q[g] <= d_i;
        end else begin
          chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_cnt.sv
module dsadc_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         max_o
);
  logic [W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign q_o   = cnt_q;
  assign max_o = &cnt_q;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_neg_i,
  output logic         az_sw_o,
  output logic         in_sel_o,
  output logic         ref_sel_o,
  output logic [N-1:0] result_o,
  output logic         eoc_o,
  output logic         ovr_o
);
  localparam logic [N-1:0] FULL = {N{1'b1}};

  logic         rst_s_n;
  logic         neg_s;
  logic [N-1:0] cnt;
  logic         cnt_max;
  logic         cnt_clr, cnt_en;
  phase_t       ph_d, ph_q;
  logic [N-1:0] res_d, res_q;
  logic         eoc_d, eoc_q, ovr_d, ovr_q;
  logic         res_en;

  // reset: asserted asynchronously, released on a clock edge
  dsadc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_s_n)
  );

  dsadc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_cmp_sync (
    .clk(clk), .rst_n(rst_s_n), .d_i(cmp_neg_i), .q_o(neg_s)
  );

  dsadc_cnt #(.W(N)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .clr_i(cnt_clr), .en_i(cnt_en),
    .q_o(cnt), .max_o(cnt_max)
  );

  // next-state logic
  always_comb begin
    ph_d    = ph_q;
    res_d   = res_q;
    eoc_d   = eoc_q;
    ovr_d   = ovr_q;
    res_en  = 1'b0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    unique case (ph_q)
      PH_ZERO: begin
        if (start_i) begin
          ph_d    = PH_UP;
          cnt_clr = 1'b1;
          eoc_d   = 1'b0;
          ovr_d   = 1'b0;
        end
      end
      PH_UP: begin
        cnt_en = 1'b1;               // wraps to zero after 2^N clocks
        if (cnt_max) ph_d = PH_DOWN;
      end
      PH_DOWN: begin
        if (!neg_s) begin
          ph_d   = PH_ZERO;
          res_en = 1'b1;
          res_d  = cnt;
          eoc_d  = 1'b1;
        end else if (cnt_max) begin
          ph_d   = PH_ZERO;
          res_en = 1'b1;
          res_d  = FULL;
          eoc_d  = 1'b1;
          ovr_d  = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: ph_d = PH_ZERO;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q  <= PH_ZERO;
      res_q <= '0;
      eoc_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      eoc_q <= eoc_d;
      ovr_q <= ovr_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign az_sw_o   = (ph_q == PH_ZERO);
  assign in_sel_o  = (ph_q == PH_UP);
  assign ref_sel_o = (ph_q == PH_DOWN);
  assign result_o  = res_q;
  assign eoc_o     = eoc_q;
  assign ovr_o     = ovr_q;

  // R9
  sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({az_sw_o, in_sel_o, ref_sel_o}));

  // R3
  runup_end_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_sel_o && cnt_max) |=> (ref_sel_o && cnt == '0));

  // R6
  ovr_sat_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ovr_o) |-> (result_o == FULL && eoc_o));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eoc_o && !start_i) |=> (eoc_o && $stable(result_o) && $stable(ovr_o)));

  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_sel_o && start_i && !cnt_max) |=> in_sel_o);

  // R5
  eoc_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(eoc_o) |-> (az_sw_o && $past(ref_sel_o)));
endmodule

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int FULLV = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         cmp_neg_i = 1'b1;
  logic         az_sw_o, in_sel_o, ref_sel_o, eoc_o, ovr_o;
  logic [N-1:0] result_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_P/2) clk = ~clk;

  dsadc_seq #(.N(N)) u_dsadc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_neg_i(cmp_neg_i),
    .az_sw_o(az_sw_o), .in_sel_o(in_sel_o), .ref_sel_o(ref_sel_o),
    .result_o(result_o), .eoc_o(eoc_o), .ovr_o(ovr_o)
  );

  function automatic int exp_res(input int d);
    return (d + 2 > FULLV) ? FULLV : d + 2;
  endfunction
  function automatic int exp_ovr(input int d);
    return (d + 2 > FULLV) ? 1 : 0;
  endfunction
  function automatic int exp_rd(input int d);
    return (d + 3 > FULLV + 1) ? FULLV + 1 : d + 3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic convert(input int d, input bit mid_start);
    int up;
    int rd;
    int res0;
    @(negedge clk);
    start_i   = 1'b1;
    cmp_neg_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 az open", az_sw_o, 0);
    check("R2 input selected", in_sel_o, 1);
    check("R7 eoc cleared", eoc_o, 0);
    check("R7 ovr cleared", ovr_o, 0);
    up = 1;
    while (!ref_sel_o && up < 1000) begin
      @(negedge clk);
      if (in_sel_o) up++;
      start_i = (mid_start && up == 5);   // R8 stimulus in run-up
    end
    start_i = 1'b0;
    check("R3 run-up length", up, FULLV + 1);
    check("R3 ref selected", {in_sel_o, ref_sel_o}, 1);
    rd = 1;
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      if (ref_sel_o) rd++;
      start_i = (mid_start && rd == 3);   // R8 stimulus in run-down
    end
    start_i   = 1'b0;
    cmp_neg_i = 1'b0;
    while (!eoc_o && rd < 1000) begin
      @(negedge clk);
      if (ref_sel_o) rd++;
    end
    check("R5 run-down length", rd, exp_rd(d));
    check(exp_ovr(d) ? "R6 saturated result" : "R4 result", result_o, exp_res(d));
    check("R6 overrange flag", ovr_o, exp_ovr(d));
    check("R5 eoc", eoc_o, 1);
    check("R1 idle switches", {az_sw_o, in_sel_o, ref_sel_o}, 3'b100);
    res0 = result_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmp_neg_i = $urandom % 2;
    end
    @(negedge clk);
    @(negedge clk);
    check("R7 result held", result_o, res0);
    check("R7 eoc held", {eoc_o, ovr_o}, {1'b1, exp_ovr(d) == 1});
    cmp_neg_i = 1'b1;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 reset switches", {az_sw_o, in_sel_o, ref_sel_o}, 3'b100);
    check("R1 reset flags", {eoc_o, ovr_o}, 0);
    check("R1 reset result", result_o, 0);
    // directed corners
    convert(0, 1'b0);
    convert(FULLV - 2, 1'b0);   // R6 boundary: exactly full without overrange
    convert(FULLV - 1, 1'b0);   // R6 first overrange
    convert(40, 1'b1);          // R8 starts during both phases
    convert(FULLV + 30, 1'b1);
    for (int i = 0; i < 12; i++) begin
      convert($urandom % (FULLV + 40), ($urandom % 3) == 0);
    end
    finish_run();
  end
endmodule